// File: doc/BRIEF.md
# HDLC Frame Receiver with Per-Byte Status

This block takes a serial HDLC line, one bit per cycle in which the bit-valid strobe is high, and turns it into a byte stream. While hunting it searches for the flag octet and locks on. Once locked it removes the zeros inserted for transparency and runs a CRC over every frame bit. Each recovered byte leaves on a byte-wide output together with its own status tags. Only the last byte of a frame carries end-of-frame, and with it the short-frame, CRC-error and residual-bit results.

Frames do not have to hold a whole number of bytes. A final fragment of one to seven bits is delivered right-aligned, and the number of valid bits is given with it. A pulse on the flag-search command drops the frame in progress. The receiver then ignores the line until it sees another flag. Seven ones in a row abort the current frame in the same way.

Top module: `hdlc_rx_status`

## Requirements
- R1: Frame bits are received LSB first and packed into bytes in arrival order. The first bit of each byte lands in out_data[0]. Every byte except the last of a frame has out_eof, out_short, out_crc_err and out_resid all low. The last byte has out_eof high.
- R2: The flag is 0x7E. A flag while hunting opens a frame. A flag inside a frame closes it and also opens the next one. Two flags with no data between them produce no output.
- R3: Inside a frame, a 0 that follows five consecutive 1s is removed and is never delivered as data.
- R4: The CRC is CRC-16 with polynomial x^16+x^12+x^5+1, bit-reflected, preset to 0xFFFF at each flag and run over every delivered bit. out_crc_err on the last byte is high exactly when the final register value differs from 0xF0B8.
- R5: out_short on the last byte is high exactly when the frame held fewer than 32 bits between its flags, counted after zero removal.
- R6: When the frame length is not a multiple of 8, out_resid is high on the last byte and out_resid_bits gives the length mod 8. The k remaining bits sit in out_data[k-1:0] and the upper bits are zero. In every other case out_resid is low and out_resid_bits is 0.
- R7: A cycle with hunt_cmd high discards the current frame. No byte of that frame appears afterwards, and the next frame after a following flag is received normally.
- R8: Seven consecutive 1s inside a frame abort it. No further byte of that frame is delivered, and reception resumes at the next flag.
- R9: After reset, out_valid is low, and no byte is delivered before the first flag.
- R10: rx_bit is only sampled in cycles with rx_en high. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial line data |
| rx_en | input | 1 | rx_bit is valid this cycle |
| hunt_cmd | input | 1 | Flag-search command: drop the frame and wait for a flag |
| out_valid | output | 1 | A byte is delivered this cycle |
| out_data | output | 8 | Received byte, first bit in bit 0 |
| out_eof | output | 1 | Last byte of a frame |
| out_short | output | 1 | Frame shorter than 32 bits |
| out_crc_err | output | 1 | CRC residue check failed |
| out_resid | output | 1 | Last byte holds fewer than 8 bits |
| out_resid_bits | output | 3 | Number of valid bits in a partial last byte |

## Verification
The hardest cases to reach from the ports are a closing flag that arrives while a full byte is still waiting to learn whether it is the last one, and a partial fragment whose bits were zero-stuffed. The bench reaches both by sweeping the payload length bit by bit from 1 to 40, with and without an appended check sequence, under patterns with long runs of ones. It also varies the spacing between strobes and toggles rx_bit in the idle cycles. The abort and flag-search cases are driven in the middle of a frame, and each is followed straight away by a frame that must arrive intact.

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status #(
  parameter int          MIN_BITS = 32,
  parameter logic [7:0]  FLAG     = 8'h7E,
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_en,
  input  logic       hunt_cmd,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_eof,
  output logic       out_short,
  output logic       out_crc_err,
  output logic       out_resid,
  output logic [2:0] out_resid_bits
);
  localparam int NBW = $clog2(MIN_BITS + 1);

  logic [7:0]     win, keep, acc, pend;
  logic [2:0]     ones, cnt;
  logic           in_frame, closing, pend_v;
  logic [15:0]    crc;
  logic [NBW-1:0] nbits;

  wire [7:0]  win_n    = {rx_bit, win[7:1]};
  wire        flag_hit = rx_en && (win_n == FLAG);
  wire        abort_hit = rx_en && in_frame && (ones == 3'd6) && rx_bit;
  wire        stuffed  = (ones == 3'd5) && !rx_bit;
  wire        dbit     = win[0];
  wire        dbit_v   = rx_en && in_frame && keep[0];
  wire [15:0] crc_step = {1'b0, crc[15:1]} ^ ((crc[0] ^ dbit) ? CRC_POLY : 16'h0000);
  wire [7:0]  acc_n    = {dbit, acc[7:1]};
  wire [7:0]  tail     = acc >> (4'd8 - {1'b0, cnt});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0; keep <= '0; ones <= '0;
      in_frame <= 1'b0; closing <= 1'b0;
      acc <= '0; cnt <= '0; pend <= '0; pend_v <= 1'b0;
      crc <= CRC_INIT; nbits <= '0;
      out_valid <= 1'b0; out_data <= '0; out_eof <= 1'b0; out_short <= 1'b0;
      out_crc_err <= 1'b0; out_resid <= 1'b0; out_resid_bits <= '0;
    end else begin
      out_valid <= 1'b0;
      if (rx_en) begin
        win  <= win_n;
        keep <= {!stuffed, keep[7:1]};
        ones <= rx_bit ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
      end
      if (hunt_cmd) begin
        in_frame <= 1'b0;
        closing  <= 1'b0;
        pend_v   <= 1'b0;
      end else if (closing) begin
        closing <= 1'b0;
        if (nbits != '0) begin
          out_valid      <= 1'b1;
          out_data       <= (cnt == 3'd0) ? pend : tail;
          out_eof        <= 1'b1;
          out_short      <= nbits < NBW'(MIN_BITS);
          out_crc_err    <= crc != CRC_GOOD;
          out_resid      <= cnt != 3'd0;
          out_resid_bits <= cnt;
        end
        crc <= CRC_INIT; cnt <= '0; nbits <= '0; acc <= '0; pend_v <= 1'b0;
      end else begin
        if (dbit_v) begin
          acc <= acc_n;
          cnt <= cnt + 3'd1;
          crc <= crc_step;
          if (nbits < NBW'(MIN_BITS)) nbits <= nbits + 1'b1;
          if (pend_v) begin
            out_valid      <= 1'b1;
            out_data       <= pend;
            out_eof        <= 1'b0;
            out_short      <= 1'b0;
            out_crc_err    <= 1'b0;
            out_resid      <= 1'b0;
            out_resid_bits <= '0;
          end
          pend_v <= (cnt == 3'd7);
          if (cnt == 3'd7) pend <= acc_n;
        end
        if (abort_hit) begin
          in_frame <= 1'b0;
          pend_v   <= 1'b0;
        end else if (flag_hit) begin
          keep <= '0;
          if (in_frame) closing <= 1'b1;
          else begin
            in_frame <= 1'b1;
            crc <= CRC_INIT; cnt <= '0; nbits <= '0; acc <= '0; pend_v <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_status_chk.sv
module hdlc_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hunt_cmd,
  input logic       out_valid,
  input logic       out_eof,
  input logic       out_short,
  input logic       out_crc_err,
  input logic       out_resid,
  input logic [2:0] out_resid_bits
);
  // R1
  mid_byte_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eof |-> !out_short && !out_crc_err && !out_resid);

  // R1
  eof_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |=> !out_valid);

  // R6
  resid_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_resid |-> out_eof);

  // R6
  resid_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_resid |-> out_resid_bits == 3'd0);

  // R7
  hunt_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_cmd |=> !out_valid);
endmodule

bind hdlc_rx_status hdlc_rx_status_chk u_chk (.*);

// File: tb/sim_hdlc_rx_status.sv
module sim_hdlc_rx_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, rx_en = 1'b0, hunt_cmd = 1'b0;
  logic out_valid, out_eof, out_short, out_crc_err, out_resid;
  logic [7:0] out_data;
  logic [2:0] out_resid_bits;

  always #4 clk = ~clk;

  hdlc_rx_status u0 (.*);

  int nchk = 0, nerr = 0;
  int cap_total = 0;
  logic [7:0] cap_d [0:1023];
  logic [6:0] cap_s [0:1023];
  logic fb [0:255];
  int flen;
  int gap = 0;
  int tx_ones = 0;
  bit done = 0;

  always @(negedge clk) if (rst_n && out_valid) begin
    cap_d[cap_total % 1024] = out_data;
    cap_s[cap_total % 1024] = {out_eof, out_short, out_crc_err, out_resid, out_resid_bits};
    cap_total++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b; rx_en = 1'b1;
    @(posedge clk); #1;
    rx_en = 1'b0; rx_bit = ~b;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic send_flag();
    send_bit(0); repeat (6) send_bit(1); send_bit(0);
    tx_ones = 0;
  endtask

  task automatic send_data(input int n);
    for (int i = 0; i < n; i++) begin
      send_bit(fb[i]);
      if (fb[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
      end else tx_ones = 0;
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      logic f = c[0] ^ fb[i];
      c = c >> 1;
      if (f) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic logic pat(input int p, input int i, input int len);
    case (p)
      0: return 1'b1;
      1: return (i % 3) != 2;
      default: return 1'(((i * 7 + len * 13) >> 2) & 1) ^ 1'(i % 5 == 0);
    endcase
  endfunction

  task automatic build(input int len, input int p, input bit add_fcs, input bit corrupt);
    logic [15:0] fcs;
    for (int i = 0; i < len; i++) fb[i] = pat(p, i, len);
    flen = len;
    if (add_fcs) begin
      fcs = ~crc_of(len);
      for (int i = 0; i < 16; i++) fb[len + i] = fcs[i];
      flen = len + 16;
    end
    if (corrupt) fb[0] = ~fb[0];
  endtask

  task automatic check_frame(input int base, input string req);
    int nb = (flen + 7) / 8;
    int rb = flen % 8;
    logic [15:0] res = crc_of(flen);
    chk(cap_total - base == nb, req, "byte count", cap_total - base, nb);
    if (cap_total - base != nb) return;
    for (int j = 0; j < nb; j++) begin
      logic [7:0] ed = '0;
      logic [6:0] es = '0;
      int idx = (base + j) % 1024;
      for (int i = 0; i < 8; i++) if (j * 8 + i < flen) ed[i] = fb[j * 8 + i];
      if (j == nb - 1) es = {1'b1, 1'(flen < 32), 1'(res != 16'hF0B8), 1'(rb != 0), 3'(rb)};
      chk(cap_d[idx] == ed, req, "data (R1 R3 R6)", cap_d[idx], ed);
      chk(cap_s[idx][6] == es[6], req, "eof (R1)", cap_s[idx][6], es[6]);
      chk(cap_s[idx][5] == es[5], req, "short (R5)", cap_s[idx][5], es[5]);
      chk(cap_s[idx][4] == es[4], req, "crc error (R4)", cap_s[idx][4], es[4]);
      chk(cap_s[idx][3:0] == es[3:0], req, "residual (R6)", cap_s[idx][3:0], es[3:0]);
    end
  endtask

  task automatic settle();
    repeat (4) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state and no output before the first flag
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    for (int i = 0; i < 40; i++) send_bit(1'(i % 4 != 0));
    settle();
    chk(cap_total == 0, "R9", "bytes before first flag", cap_total, 0);

    // R2: back-to-back flags give nothing
    base = cap_total;
    send_flag(); send_flag(); send_flag(); settle();
    chk(cap_total == base, "R2", "empty frames", cap_total - base, 0);

    // Sweep of lengths, patterns and check-sequence modes (R1 R3 R4 R5 R6 R10)
    for (int mode = 0; mode < 3; mode++)
      for (int p = 0; p < 3; p++)
        for (int len = 1; len <= 40; len++) begin
          gap = len % 3;
          build(len, p, mode != 2, mode == 1);
          send_flag();
          base = cap_total;
          send_data(flen);
          send_flag();
          settle();
          check_frame(base, mode == 0 ? "R4" : (mode == 1 ? "R4" : "R6"));
        end

    // R7: flag-search mid-frame
    gap = 1;
    build(40, 2, 1'b1, 1'b0);
    send_flag();
    send_data(24);
    hunt_cmd = 1'b1; @(posedge clk); #1; hunt_cmd = 1'b0;
    base = cap_total;
    for (int i = 24; i < flen; i++) send_bit(fb[i]);
    send_flag();
    build(20, 1, 1'b1, 1'b0);
    send_data(flen);
    send_flag();
    settle();
    check_frame(base, "R7");

    // R8: abort with seven ones mid-frame
    gap = 0;
    build(40, 1, 1'b1, 1'b0);
    send_flag();
    send_data(30);
    repeat (8) send_bit(1);
    base = cap_total;
    repeat (5) send_bit(1);
    send_flag();
    build(24, 2, 1'b1, 1'b0);
    send_data(flen);
    send_flag();
    settle();
    check_frame(base, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule